// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-facing control and status front end of an eight-channel DMA controller. A simple 32-bit register port (byte offset, write strobe, write data, combinational read data) lets software enable channels, pick a hardware trigger source for each, set the descriptor table base and enable interrupts. Software can also fire triggers, watch pending, running and paused channels, and acknowledge finished transfers. The bus-master data mover is outside the block. It sees a pending-request vector and answers with a grant (channel number), completion pulses and a pause level per channel.

Each channel has a small state machine with four states. CH_OFF is disabled. CH_IDLE is enabled and waiting for a trigger. CH_PEND holds a trigger that is waiting for the engine. CH_RUN is granted and transferring. The transitions are as follows. CH_OFF goes to CH_IDLE on an enable write of 1. CH_IDLE goes to CH_PEND on a software or selected hardware trigger. CH_PEND goes to CH_RUN on a grant for that channel. CH_RUN goes to CH_IDLE on a completion pulse. CH_IDLE, CH_PEND and CH_RUN all go to CH_OFF on an enable write of 0, and leaving CH_RUN this way raises a one-cycle abort.

When a grant is accepted, the block registers the channel's control descriptor address (base + 16·n) and its reload descriptor address (base + 128 + 16·n) for the engine.

Top module: `dmacr_top`

## Requirements
- R1: After reset all registers read 0, except the table base at offset 0x04, which reads 0x0008_0000. `irq`, `eng_req`, `desc_vld` and `ch_abort` are 0.
- R2: Offset 0x00 holds one enable bit per channel in bits 7:0 (bit n is channel n). Bits 31:8 read 0. The enable readback is 1 in every state except CH_OFF.
- R3: A disabled channel ignores software and hardware triggers. Its trigger flag at offset 0x10 stays 0 and its `eng_req` bit stays 0.
- R4: Writing 1 to bit n at offset 0x10 triggers an enabled idle channel. The bit then reads 1 and `eng_req[n]` is 1 until a grant is accepted, and then both clear. Writing 0 has no effect.
- R5: Offset 0x0C holds a 4-bit source field per channel in bits 4n+3:4n. A value of 0 means no hardware source. A value k from 1 to 15 makes a high `hw_trig[k]` at a clock edge trigger the channel.
- R6: A grant (`eng_grant_vld` with `eng_grant_ch`=n) for a pending channel moves it to running. In the next cycle `desc_vld` is 1, `desc_addr` is base+16·n and `reload_addr` is base+128+16·n. A grant for a channel that is not pending is ignored.
- R7: A completion pulse on `eng_done[n]` for a running channel sets end flag bit n at offset 0x14 and clears its run bit. Writing 1 clears the flag and writing 0 has no effect. If a completion and a clearing write come in the same cycle, the flag is set.
- R8: `irq` is 1 exactly when some channel has both its end flag and its interrupt enable bit (offset 0x08, bit n) set.
- R9: Writing 0 to the enable bit of a running channel drives `ch_abort[n]` high during that write cycle, and the channel returns to CH_OFF. A pending channel that is disabled drops its trigger and does not abort.
- R10: At offset 0x04, bits 31:10 are writable. Bits 9:0 always read 0.
- R11: Offset 0x18 reads the run bits and offset 0x1C reads `eng_pause` masked by the run bits. Writes to either offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| hw_trig | input | 16 | Hardware trigger lines; line 0 is never selected |
| eng_req | output | 8 | Channels with a pending trigger |
| eng_grant_vld | input | 1 | Engine accepts a channel |
| eng_grant_ch | input | 3 | Channel being accepted |
| eng_done | input | 8 | Completion pulses per channel |
| eng_pause | input | 8 | Engine pause level per channel |
| desc_vld | output | 1 | Descriptor addresses valid (one cycle) |
| desc_addr | output | 32 | Control descriptor address of the granted channel |
| reload_addr | output | 32 | Reload descriptor address of the granted channel |
| ch_abort | output | 8 | Force-termination pulse per channel |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the engine raises `eng_done[n]` only for a channel it has been granted. They also assume it changes `eng_grant_vld`, `eng_grant_ch` and the bus signals only between clock edges. The bench drives every input on the falling edge and sends completions only to running channels. It issues one grant for a channel that is not pending, to show that such a grant is ignored. Interrupt rises are assumed to follow only a completion or a register write, and the stimulus creates no other cause.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_IDLE = 2'd1,
        CH_PEND = 2'd2,
        CH_RUN  = 2'd3
    } ch_state_e;

    // register index = byte offset [4:2]
    localparam logic [2:0] RG_EN    = 3'd0;
    localparam logic [2:0] RG_BASE  = 3'd1;
    localparam logic [2:0] RG_IE    = 3'd2;
    localparam logic [2:0] RG_TSEL  = 3'd3;
    localparam logic [2:0] RG_TFLG  = 3'd4;
    localparam logic [2:0] RG_END   = 3'd5;
    localparam logic [2:0] RG_RUN   = 3'd6;
    localparam logic [2:0] RG_PAUSE = 3'd7;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned BASE_ALIGN = 10;
endpackage

// File: rtl/dmacr_chan_fsm.sv
module dmacr_chan_fsm
    import dmacr_pkg::*;
#(
    parameter int unsigned HW_N  = 16,
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             sw_trig,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [HW_N-1:0]  hw_trig,
    input  logic             grant,
    input  logic             done,
    output logic             enabled,
    output logic             pending,
    output logic             running,
    output logic             abort
);
    ch_state_e state_q, state_d;
    logic      hw_hit;
    logic      trig;

    assign hw_hit = (src_sel != '0) && hw_trig[src_sel];
    assign trig   = sw_trig || hw_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF:  if (en_set) state_d = CH_IDLE;
            CH_IDLE: if (en_clr) state_d = CH_OFF;
                     else if (trig) state_d = CH_PEND;
            CH_PEND: if (en_clr) state_d = CH_OFF;
                     else if (grant) state_d = CH_RUN;
            CH_RUN:  if (en_clr) state_d = CH_OFF;
                     else if (done) state_d = CH_IDLE;
            default: state_d = CH_OFF;
        endcase
    end

    always_comb begin
        enabled = 1'b0;
        pending = 1'b0;
        running = 1'b0;
        abort   = 1'b0;
        unique case (state_q)
            CH_OFF:  ;
            CH_IDLE: enabled = 1'b1;
            CH_PEND: begin
                enabled = 1'b1;
                pending = 1'b1;
            end
            CH_RUN: begin
                enabled = 1'b1;
                running = 1'b1;
                abort   = en_clr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dmacr_regfile.sv
module dmacr_regfile
    import dmacr_pkg::*;
#(
    parameter int unsigned NCH    = 8,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned ADDR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NCH-1:0]       en_vec,
    input  logic [NCH-1:0]       pend_vec,
    input  logic [NCH-1:0]       run_vec,
    input  logic [NCH-1:0]       eng_done,
    input  logic [NCH-1:0]       eng_pause,
    output logic [NCH-1:0]       en_set,
    output logic [NCH-1:0]       en_clr,
    output logic [NCH-1:0]       sw_trig,
    output logic [NCH*SEL_W-1:0] tsel,
    output logic [DATA_W-1:0]    tbl_base,
    output logic [NCH-1:0]       end_flg,
    output logic [NCH-1:0]       end_clr,
    output logic                 irq
);
    localparam int unsigned HI_W = DATA_W - BASE_ALIGN;
    localparam logic [HI_W-1:0] BASE_RST = HI_W'(32'h0008_0000 >> BASE_ALIGN);

    logic [2:0]      idx;
    logic [HI_W-1:0] base_hi;
    logic [NCH-1:0]  ie;
    logic [NCH-1:0]  done_set;
    logic [NCH-1:0]  pause_vec;
    logic            unused_bits;

    assign idx         = bus_addr[4:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[BASE_ALIGN-1:0]};

    assign en_set  = (bus_we && idx == RG_EN)   ? bus_wdata[NCH-1:0]  : '0;
    assign en_clr  = (bus_we && idx == RG_EN)   ? ~bus_wdata[NCH-1:0] : '0;
    assign sw_trig = (bus_we && idx == RG_TFLG) ? bus_wdata[NCH-1:0]  : '0;
    assign end_clr = (bus_we && idx == RG_END)  ? bus_wdata[NCH-1:0]  : '0;

    assign done_set  = eng_done & run_vec;
    assign pause_vec = eng_pause & run_vec;
    assign tbl_base  = {base_hi, {BASE_ALIGN{1'b0}}};
    assign irq       = |(end_flg & ie);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_hi <= BASE_RST;
            ie      <= '0;
            tsel    <= '0;
            end_flg <= '0;
        end else begin
            if (bus_we && idx == RG_BASE) base_hi <= bus_wdata[DATA_W-1:BASE_ALIGN];
            if (bus_we && idx == RG_IE)   ie      <= bus_wdata[NCH-1:0];
            if (bus_we && idx == RG_TSEL) tsel    <= bus_wdata[NCH*SEL_W-1:0];
            // a completion in the same cycle as a clear keeps the flag set
            end_flg <= (end_flg & ~end_clr) | done_set;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            RG_EN:    bus_rdata = DATA_W'(en_vec);
            RG_BASE:  bus_rdata = tbl_base;
            RG_IE:    bus_rdata = DATA_W'(ie);
            RG_TSEL:  bus_rdata = DATA_W'(tsel);
            RG_TFLG:  bus_rdata = DATA_W'(pend_vec);
            RG_END:   bus_rdata = DATA_W'(end_flg);
            RG_RUN:   bus_rdata = DATA_W'(run_vec);
            RG_PAUSE: bus_rdata = DATA_W'(pause_vec);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmacr_addr_gen.sv
module dmacr_addr_gen
    import dmacr_pkg::*;
#(
    parameter int unsigned NCH        = 8,
    parameter int unsigned DESC_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DATA_W-1:0]      tbl_base,
    input  logic                   grant_vld,
    input  logic [$clog2(NCH)-1:0] grant_ch,
    input  logic [NCH-1:0]         pend_vec,
    output logic [NCH-1:0]         grant_vec,
    output logic                   desc_vld,
    output logic [DATA_W-1:0]      desc_addr,
    output logic [DATA_W-1:0]      reload_addr
);
    localparam int unsigned DESC_SH = $clog2(DESC_BYTES);
    localparam logic [DATA_W-1:0] RELOAD_OFS = DATA_W'(NCH * DESC_BYTES);

    logic              accept;
    logic [DATA_W-1:0] ch_ofs;

    for (genvar n = 0; n < NCH; n++) begin : g_gnt
        assign grant_vec[n] = grant_vld && (grant_ch == n[$clog2(NCH)-1:0]);
    end

    assign accept = |(grant_vec & pend_vec);
    assign ch_ofs = DATA_W'(grant_ch) << DESC_SH;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_vld    <= 1'b0;
            desc_addr   <= '0;
            reload_addr <= '0;
        end else begin
            desc_vld <= accept;
            if (accept) begin
                desc_addr   <= tbl_base + ch_ofs;
                reload_addr <= tbl_base + RELOAD_OFS + ch_ofs;
            end
        end
    end
endmodule

// File: rtl/dmacr_top.sv
module dmacr_top
    import dmacr_pkg::*;
#(
    parameter int unsigned NCH    = 8,
    parameter int unsigned HW_N   = 16,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DESC_BYTES = 16,
    localparam int unsigned SEL_W = $clog2(HW_N),
    localparam int unsigned CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [HW_N-1:0]   hw_trig,
    output logic [NCH-1:0]    eng_req,
    input  logic              eng_grant_vld,
    input  logic [CH_W-1:0]   eng_grant_ch,
    input  logic [NCH-1:0]    eng_done,
    input  logic [NCH-1:0]    eng_pause,
    output logic              desc_vld,
    output logic [31:0]       desc_addr,
    output logic [31:0]       reload_addr,
    output logic [NCH-1:0]    ch_abort,
    output logic              irq
);
    logic [NCH-1:0]       en_vec, pend_vec, run_vec;
    logic [NCH-1:0]       en_set, en_clr, sw_trig, grant_vec;
    logic [NCH-1:0]       end_vec, end_clr_vec;
    logic [NCH*SEL_W-1:0] tsel;
    logic [31:0]          tbl_base;

    assign eng_req = pend_vec;

    dmacr_regfile #(.NCH(NCH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .en_vec(en_vec), .pend_vec(pend_vec), .run_vec(run_vec),
        .eng_done(eng_done), .eng_pause(eng_pause),
        .en_set(en_set), .en_clr(en_clr), .sw_trig(sw_trig), .tsel(tsel),
        .tbl_base(tbl_base), .end_flg(end_vec), .end_clr(end_clr_vec), .irq(irq)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dmacr_chan_fsm #(.HW_N(HW_N), .SEL_W(SEL_W)) u_fsm (
            .clk(clk), .rst_n(rst_n),
            .en_set(en_set[n]), .en_clr(en_clr[n]), .sw_trig(sw_trig[n]),
            .src_sel(tsel[n*SEL_W +: SEL_W]), .hw_trig(hw_trig),
            .grant(grant_vec[n]), .done(eng_done[n]),
            .enabled(en_vec[n]), .pending(pend_vec[n]),
            .running(run_vec[n]), .abort(ch_abort[n])
        );
    end

    dmacr_addr_gen #(.NCH(NCH), .DESC_BYTES(DESC_BYTES)) u_addr (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
        .grant_vld(eng_grant_vld), .grant_ch(eng_grant_ch), .pend_vec(pend_vec),
        .grant_vec(grant_vec), .desc_vld(desc_vld),
        .desc_addr(desc_addr), .reload_addr(reload_addr)
    );
endmodule

// File: rtl/dmacr_chk.sv
module dmacr_chk #(
    parameter int unsigned NCH    = 8,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_rdata,
    input logic [NCH-1:0]    eng_req,
    input logic [NCH-1:0]    en_vec,
    input logic [NCH-1:0]    run_vec,
    input logic [NCH-1:0]    end_vec,
    input logic [NCH-1:0]    end_clr_vec,
    input logic [NCH-1:0]    eng_done,
    input logic              eng_grant_vld,
    input logic              desc_vld,
    input logic [31:0]       desc_addr,
    input logic [31:0]       reload_addr,
    input logic [NCH-1:0]    ch_abort,
    input logic              irq
);
    p_req_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req & ~en_vec) == '0);

    p_desc_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_vld |-> $past(eng_grant_vld));

    p_desc_layout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_vld |-> (desc_addr[3:0] == 4'd0 && reload_addr == desc_addr + 32'd128));

    p_end_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_vec != '0) |=> (($past(end_vec) & ~$past(end_clr_vec) & ~end_vec) == '0));

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(eng_done) != '0 || $past(bus_we)));

    p_abort_only_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_abort & ~run_vec) == '0);

    p_abort_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_abort != '0) |=> ((run_vec & $past(ch_abort)) == '0));

    p_base_low_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[4:2] == 3'd1) |-> (bus_rdata[9:0] == 10'd0));
endmodule

bind dmacr_top dmacr_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .eng_req(eng_req), .en_vec(en_vec), .run_vec(run_vec),
    .end_vec(end_vec), .end_clr_vec(end_clr_vec), .eng_done(eng_done),
    .eng_grant_vld(eng_grant_vld), .desc_vld(desc_vld), .desc_addr(desc_addr),
    .reload_addr(reload_addr), .ch_abort(ch_abort), .irq(irq)
);

// File: tb/sim_dmacr_top.sv
module sim_dmacr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] hw_trig = '0;
    logic [7:0]  eng_req;
    logic        eng_grant_vld = 1'b0;
    logic [2:0]  eng_grant_ch = '0;
    logic [7:0]  eng_done = '0;
    logic [7:0]  eng_pause = '0;
    logic        desc_vld;
    logic [31:0] desc_addr, reload_addr;
    logic [7:0]  ch_abort;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [63:0] exp_q[$];

    always #5 clk = ~clk;

    dmacr_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_trig(hw_trig),
        .eng_req(eng_req), .eng_grant_vld(eng_grant_vld), .eng_grant_ch(eng_grant_ch),
        .eng_done(eng_done), .eng_pause(eng_pause), .desc_vld(desc_vld),
        .desc_addr(desc_addr), .reload_addr(reload_addr), .ch_abort(ch_abort), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic pulse_hw(input int k);
        @(negedge clk); hw_trig = 16'(1) << k;
        @(negedge clk); hw_trig = '0;
    endtask

    task automatic pulse_done(input logic [7:0] m);
        @(negedge clk); eng_done = m;
        @(negedge clk); eng_done = '0;
    endtask

    // driver side of the scoreboard: push expected descriptor pair
    task automatic grant(input logic [2:0] ch, input bit expect_it, input logic [31:0] base);
        @(negedge clk);
        eng_grant_vld = 1'b1; eng_grant_ch = ch;
        if (expect_it) exp_q.push_back({base + 32'(ch) * 16, base + 32'd128 + 32'(ch) * 16});
        @(negedge clk);
        eng_grant_vld = 1'b0;
    endtask

    // monitor side: R6
    always @(negedge clk) begin
        if (rst_n && desc_vld) begin
            if (exp_q.size() == 0) chk("R6 unexpected desc_vld", 64'(1), 64'(0));
            else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk("R6 descriptor pair", {desc_addr, reload_addr}, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd("R1 enable", 5'h00, 32'h0);
        rd("R1 base", 5'h04, 32'h0008_0000);
        rd("R1 ie", 5'h08, 32'h0);
        rd("R1 tsel", 5'h0C, 32'h0);
        rd("R1 tflag", 5'h10, 32'h0);
        rd("R1 end", 5'h14, 32'h0);
        rd("R1 run", 5'h18, 32'h0);
        rd("R1 pause", 5'h1C, 32'h0);
        chk("R1 outputs", {56'(eng_req), irq, desc_vld, 6'(0)}, 64'h0);
        chk("R1 abort", 64'(ch_abort), 64'h0);

        // R3 triggers on disabled channels
        wr(5'h10, 32'h01);
        rd("R3 sw trig disabled", 5'h10, 32'h0);
        chk("R3 eng_req disabled", 64'(eng_req), 64'h0);
        wr(5'h0C, 32'h0000_0030);
        pulse_hw(3);
        rd("R3 hw trig disabled", 5'h10, 32'h0);

        // R2 enable width
        wr(5'h00, 32'hFFFF_FFFF);
        rd("R2 enable bits", 5'h00, 32'h0000_00FF);
        wr(5'h00, 32'h0);
        rd("R2 enable clear", 5'h00, 32'h0);

        // R10 base alignment
        wr(5'h04, 32'h1234_57FF);
        rd("R10 base", 5'h04, 32'h1234_5400);
        base = 32'h1234_5400;

        // R4 software trigger
        wr(5'h00, 32'h04);
        wr(5'h10, 32'h00);
        rd("R4 write 0 no trigger", 5'h10, 32'h0);
        wr(5'h10, 32'h04);
        rd("R4 pending flag", 5'h10, 32'h04);
        chk("R4 eng_req", 64'(eng_req), 64'h04);

        // R6 grant
        grant(3'd2, 1'b1, base);
        rd("R4 flag cleared by grant", 5'h10, 32'h0);
        rd("R6 running", 5'h18, 32'h04);
        grant(3'd5, 1'b0, base);
        rd("R6 ignored grant", 5'h18, 32'h04);

        // R11 read-only status
        eng_pause = 8'hFF;
        rd("R11 pause masked", 5'h1C, 32'h04);
        wr(5'h18, 32'hFF);
        wr(5'h1C, 32'hFF);
        rd("R11 run after write", 5'h18, 32'h04);
        rd("R11 pause after write", 5'h1C, 32'h04);
        eng_pause = 8'h00;

        // R7 completion and write-1-clear; R8 interrupt
        pulse_done(8'h04);
        rd("R7 end flag set", 5'h14, 32'h04);
        rd("R7 run cleared", 5'h18, 32'h0);
        wr(5'h14, 32'h00);
        rd("R7 write 0 keeps flag", 5'h14, 32'h04);
        chk("R8 irq masked", 64'(irq), 64'h0);
        wr(5'h08, 32'h04);
        chk("R8 irq raised", 64'(irq), 64'h1);
        wr(5'h14, 32'h04);
        rd("R7 flag cleared", 5'h14, 32'h0);
        chk("R8 irq dropped", 64'(irq), 64'h0);

        // R5 hardware source select
        wr(5'h00, 32'h06);
        wr(5'h0C, 32'h0000_0050);
        pulse_hw(4);
        rd("R5 wrong line", 5'h10, 32'h0);
        pulse_hw(0);
        rd("R5 line 0 never selected", 5'h10, 32'h0);
        pulse_hw(5);
        rd("R5 selected line", 5'h10, 32'h02);
        grant(3'd1, 1'b1, base);
        pulse_done(8'h02);
        wr(5'h14, 32'h02);

        // R7 set wins over clear
        wr(5'h10, 32'h02);
        grant(3'd1, 1'b1, base);
        @(negedge clk);
        eng_done = 8'h02; bus_we = 1'b1; bus_addr = 5'h14; bus_wdata = 32'h02;
        @(negedge clk);
        eng_done = '0; bus_we = 1'b0;
        rd("R7 set wins", 5'h14, 32'h02);
        wr(5'h14, 32'h02);

        // R9 force termination
        wr(5'h10, 32'h02);
        wr(5'h10, 32'h04);
        grant(3'd2, 1'b1, base);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h0;
        #1;
        chk("R9 abort only running", 64'(ch_abort), 64'h04);
        @(negedge clk);
        bus_we = 1'b0;
        rd("R9 run cleared", 5'h18, 32'h0);
        rd("R9 pending dropped", 5'h10, 32'h0);
        rd("R9 channels off", 5'h00, 32'h0);
        chk("R9 no request", 64'(eng_req), 64'h0);
        chk("R9 abort released", 64'(ch_abort), 64'h0);

        repeat (2) @(negedge clk);
        chk("R6 scoreboard drained", 64'(exp_q.size()), 64'h0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule